// File: doc/BRIEF.md
# Eight-Channel Pulse-Width DAC Bank

This block produces eight pulse-width-modulated outputs for external RC filtering into analog control voltages. All channels share a single prescaler and one 8-bit period counter. Each period is 256 steps of the PWM clock. The PWM clock is the input clock divided by 8, 4, 2 or 1, chosen by a 2-bit select register.

A host loads the 8-bit width of each channel through a single-cycle write strobe. Each channel has its own address. A separate strobe loads the divider select. Written widths wait in a staging register and move to the compare logic only when the counter wraps. A period that is already running therefore always completes with one value.

Each output models an open-drain pad. It has a data bit tied to zero and an active-high enable. When the enable is high the pin is pulled low. When the enable is low the pin is released and floats high through an external pull-up.

Top module: `pwm_dac_bank`

## Requirements
- R1: In reset and right after it, the divider select is 00 (divide by 8), every width is 0, and every pad enable is 1 (pulled low).
- R2: `pad_do_o` is 0 on every cycle, so a pad can only pull low (enable 1) or float (enable 0).
- R3: With width W active, a channel is released (enable 0) for exactly W×D input-clock cycles in each period and pulled low for the rest. W=0 keeps it low for the whole period, and W=255 releases it for 255×D cycles.
- R4: The period is 256×D input-clock cycles. D is set by the select code: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 1.
- R5: A write with `wr_en_i` high to address 19+i, for i = 0 to 7, loads `wr_data_i` (bit 7 is the MSB) as the width of channel i.
- R6: A write to any address outside 19..26 changes no channel width.
- R7: A written width takes effect only when the counter wraps from 255 to 0. The period in progress keeps its old width.
- R8: Any write on `sel_wr_i`, even one that leaves the code unchanged, restarts the prescaler phase at zero on the next cycle. The next tick then comes D_new cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input (crystal) clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Width write strobe, one cycle |
| wr_addr_i | input | 5 | Width write address (19..26 valid) |
| wr_data_i | input | 8 | Write data; bits 1:0 also feed the select |
| sel_wr_i | input | 1 | Divider select write strobe |
| pad_do_o | output | 8 | Pad data bits, always 0 |
| pad_oe_o | output | 8 | Pad enables, 1 = pull low |

## Verification
The pad enables are registered one clock after the counter and the active widths. The bench therefore measures everything relative to an observed falling edge of channel 7's enable, with channel 7 held at width 1. It counts samples from that edge up to the next one, which gives the period length, and counts released samples per channel, which gives the duty. Both counts are taken on falling clock edges, so the one-cycle output latency cancels out.

A width written mid-period must leave the current window unchanged and show up in the following window. A select write issued at window sample 2 at divide-by-8 lands when the prescaler phase is 3, so the period must stretch by exactly 4 cycles to 2052.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
    localparam int unsigned NUM_CH    = 8;
    localparam int unsigned WIDTH_W   = 8;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned BASE_ADDR = 19;
    localparam int unsigned DSEL_W    = 2;
    // phase counter must reach (1 << max_shift) - 1 where max_shift = 2**DSEL_W - 1
    localparam int unsigned PHASE_W   = (1 << DSEL_W) - 1;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned DSEL_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_wr_i,
    input  logic [DSEL_W-1:0] sel_data_i,
    output logic              tick_o
);
    localparam int unsigned MAX_SH  = (1 << DSEL_W) - 1;
    localparam int unsigned PHASE_W = MAX_SH;

    typedef struct packed {
        logic [DSEL_W-1:0]  dsel;
        logic [PHASE_W-1:0] phase;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PHASE_W-1:0] last_phase;

    // highest code divides by 1, code 0 divides by 2**MAX_SH
    function automatic logic [PHASE_W-1:0] phase_limit(input logic [DSEL_W-1:0] code);
        int unsigned sh;
        sh = MAX_SH - int'(code);
        return PHASE_W'((32'd1 << sh) - 32'd1);
    endfunction

    always_comb begin
        st_d       = st_q;
        last_phase = phase_limit(st_q.dsel);
        tick_o     = (st_q.phase == last_phase);
        if (tick_o) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PHASE_W'(1);
        end
        if (sel_wr_i) begin
            st_d.dsel  = sel_data_i;
            st_d.phase = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_phase_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_wr_i |=> (st_q.phase == '0));

    p_tick_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && !sel_wr_i && st_q.dsel == '0) |=> !tick_o);
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
    parameter int unsigned WIDTH_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    output logic [WIDTH_W-1:0] cnt_o,
    output logic               wrap_o
);
    typedef struct packed {
        logic [WIDTH_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = tick_i && (st_q.cnt == '1);
        if (tick_i) begin
            st_d.cnt = st_q.cnt + WIDTH_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> (st_q.cnt == $past(st_q.cnt) + WIDTH_W'(1)));

    p_cnt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(st_q.cnt));
endmodule

// File: rtl/pwm_width_regs.sv
module pwm_width_regs #(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned WIDTH_W   = 8,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned BASE_ADDR = 19
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              wr_addr_i,
    input  logic [WIDTH_W-1:0]             wr_data_i,
    input  logic                           wrap_i,
    output logic [NUM_CH-1:0][WIDTH_W-1:0] active_o
);
    localparam int unsigned LAST_ADDR = BASE_ADDR + NUM_CH - 1;

    typedef struct packed {
        logic [NUM_CH-1:0][WIDTH_W-1:0] staged;
        logic [NUM_CH-1:0][WIDTH_W-1:0] active;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (wr_en_i && (wr_addr_i == ADDR_W'(BASE_ADDR + ch))) begin
                st_d.staged[ch] = wr_data_i;
            end
        end
        // transfer only on the period boundary
        if (wrap_i) begin
            st_d.active = st_d.staged;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    p_active_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(st_q.active));

    p_ignore_far_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && ((int'(wr_addr_i) < BASE_ADDR) || (int'(wr_addr_i) > LAST_ADDR)))
        |=> $stable(st_q.staged));
endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out #(
    parameter int unsigned WIDTH_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [WIDTH_W-1:0] cnt_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               pad_oe_o
);
    typedef struct packed {
        logic oe;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        // release while counter is below the width, pull low otherwise
        st_d.oe = !(cnt_i < width_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{oe: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign pad_oe_o = st_q.oe;

    p_zero_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (width_i == '0) |=> pad_oe_o);
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
    import pwm_dac_pkg::*;
#(
    parameter int unsigned N_CH    = NUM_CH,
    parameter int unsigned PW_W    = WIDTH_W,
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned BASE    = BASE_ADDR,
    parameter int unsigned SEL_W   = DSEL_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [PW_W-1:0] wr_data_i,
    input  logic            sel_wr_i,
    output logic [N_CH-1:0] pad_do_o,
    output logic [N_CH-1:0] pad_oe_o
);
    logic                         tick;
    logic                         wrap;
    logic [PW_W-1:0]              cnt;
    logic [N_CH-1:0][PW_W-1:0]    active;

    pwm_prescaler #(.DSEL_W(SEL_W)) u_pre (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_wr_i   (sel_wr_i),
        .sel_data_i (wr_data_i[SEL_W-1:0]),
        .tick_o     (tick)
    );

    pwm_period_counter #(.WIDTH_W(PW_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    pwm_width_regs #(
        .NUM_CH    (N_CH),
        .WIDTH_W   (PW_W),
        .ADDR_W    (AW),
        .BASE_ADDR (BASE)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .wrap_i    (wrap),
        .active_o  (active)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm_chan_out #(.WIDTH_W(PW_W)) u_out (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .cnt_i    (cnt),
            .width_i  (active[g]),
            .pad_oe_o (pad_oe_o[g])
        );
    end

    // open-drain: data bit never drives high
    assign pad_do_o = '0;
endmodule

// File: tb/pwm_dac_bank_tb.sv
module pwm_dac_bank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sel_wr = 1'b0;
    logic [7:0] pad_do;
    logic [7:0] pad_oe;

    int checks = 0;
    int errors = 0;
    int hi_cnt [8];
    int per_len;
    int exp_w [8];
    int do_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dac_bank dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .sel_wr_i  (sel_wr),
        .pad_do_o  (pad_do),
        .pad_oe_o  (pad_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_pw(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_sel(input int code);
        @(negedge clk);
        sel_wr = 1'b1; wr_data = 8'(code);
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    // sync on channel 7 enable fall, then count one period; optional stimulus at sample k
    task automatic measure(input int k, input int kind, input int addr, input int data);
        logic prev;
        int n;
        @(negedge clk);
        prev = pad_oe[7];
        forever begin
            @(negedge clk);
            if (prev && !pad_oe[7]) break;
            prev = pad_oe[7];
        end
        for (int c = 0; c < 8; c++) hi_cnt[c] = 0;
        n = 0;
        do_bad = 0;
        prev = 1'b0;
        forever begin
            if (n > 0 && prev && !pad_oe[7]) break;
            for (int c = 0; c < 8; c++) if (!pad_oe[c]) hi_cnt[c]++;
            if (pad_do != 8'h00) do_bad++;
            prev = pad_oe[7];
            wr_en = 1'b0; sel_wr = 1'b0;
            if (n == k && kind == 1) begin
                wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 8'(data);
            end
            if (n == k && kind == 2) begin
                sel_wr = 1'b1; wr_data = 8'(data);
            end
            n++;
            @(negedge clk);
        end
        wr_en = 1'b0; sel_wr = 1'b0;
        per_len = n;
    endtask

    task automatic check_duty(input string req, input int div);
        for (int c = 0; c < 8; c++)
            check(hi_cnt[c] == exp_w[c] * div, req, hi_cnt[c], exp_w[c] * div);
        check(do_bad == 0, "R2 pad data low", do_bad, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(pad_oe == 8'hFF, "R1 reset enables", pad_oe, 8'hFF);
        check(pad_do == 8'h00, "R2 reset data", pad_do, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pad_oe == 8'hFF, "R1 after reset enables", pad_oe, 8'hFF);
    endtask

    task automatic t_load_default;
        int vals [8] = '{0, 255, 128, 64, 3, 200, 17, 1};
        for (int c = 0; c < 8; c++) begin
            exp_w[c] = vals[c];
            write_pw(19 + c, vals[c]);   // R5 address map
        end
        repeat (500) @(negedge clk);
        check(pad_oe == 8'hFF, "R7 no effect before wrap", pad_oe, 8'hFF);
        measure(-1, 0, 0, 0);
        check(per_len == 2048, "R1/R4 default divide 8 period", per_len, 2048);
        check_duty("R3/R5 duty after load", 8);
    endtask

    task automatic t_deferred_update;
        measure(100, 1, 19, 90);
        check(hi_cnt[0] == 0, "R7 running period keeps old width", hi_cnt[0], 0);
        exp_w[0] = 90;
        measure(-1, 0, 0, 0);
        check(hi_cnt[0] == 720, "R7 new width next period", hi_cnt[0], 720);
        check_duty("R3 duty after update", 8);
    endtask

    task automatic t_phase_restart;
        measure(2, 2, 0, 0);
        check(per_len == 2052, "R8 phase restart stretches period", per_len, 2052);
    endtask

    task automatic t_rate(input int code, input int div);
        write_sel(code);
        measure(-1, 0, 0, 0);
        check(per_len == 256 * div, "R4 period length", per_len, 256 * div);
        check_duty("R3 duty at rate", div);
    endtask

    task automatic t_ignore;
        write_pw(18, 8'hAA);
        write_pw(27, 8'hAA);
        write_pw(31, 8'hAA);
        write_pw(0, 8'hAA);
        measure(-1, 0, 0, 0);
        check_duty("R6 out-of-range writes ignored", 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_load_default();
        t_deferred_update();
        t_phase_restart();
        t_rate(3, 1);
        t_ignore();
        t_rate(1, 4);
        t_rate(2, 2);
        t_rate(0, 8);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule